// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small, fully associative translation buffer. It turns a 32-bit virtual address into a 30-bit physical address using 4 KB pages. A lookup request carries a virtual address and a load/store flag. In the same cycle the block answers with the physical address, a hit flag and a fault code, so the next cycle can already begin exception handling. The low 12 bits pass straight through, and bits 31..12 are compared against every stored page tag at once.

Software fills the buffer through a small register interface. It writes a staging "low" register (physical page and flags) and a staging "high" register (virtual page). A command then copies both into one slot. The slot is either the one named by an index register or the one named by a free-running pseudorandom register. The pseudorandom register never names slots 0 and 1, so those two slots stay pinned. Each slot keeps a reference bit and a dirty bit, and lookups update them. A failing lookup latches its address into a bad-address register, which the refill routine reads back. A flush input invalidates every slot at once.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `lk_paddr` equals the slot's 18-bit physical page followed by `lk_vaddr[11:0]`, and `lk_hit` is 1, all in the lookup cycle.
- R2: A valid lookup that matches no valid slot gives `lk_fault`=1 (miss), `lk_hit`=0 and `lk_paddr`=0 in the same cycle.
- R3: Bad-address register (select 4, reset 0): after any lookup that faults (code 1 or 2) it holds that lookup's `lk_vaddr`. Otherwise it keeps its value.
- R4: Random register (select 1, read only) resets to 15 and steps down by one every clock. After 2 the next value is 15, so it never holds 0 or 1.
- R5: Writing select 6 (random write) copies the low and high staging registers into the slot named by the random register in that cycle.
- R6: Select 0 is the index register (bits 3..0). Select 2 is the low register: bits 17..0 physical page, bit 18 dirty, bit 19 reference, bit 20 write-allowed, bit 21 valid. Select 3 is the high register: bits 19..0 virtual page. Writing select 5 copies low/high into the slot named by the index. Writing select 7 loads low/high from that slot, using its state before the cycle's update.
- R7: A store that hits a slot with write-allowed 0 gives `lk_fault`=2 with `lk_hit`=1, and it leaves the slot's dirty bit unchanged.
- R8: Any hit sets the slot's reference bit. A store hit on a slot with write-allowed 1 also sets its dirty bit. If a write command targets the same slot in that cycle, the written values take precedence.
- R9: When several valid slots hold the same virtual page, the lowest-numbered slot supplies the translation.
- R10: A cycle with `flush` high clears every valid bit, so every lookup in the next cycle misses. The flush also wins over a write command in that cycle.
- R11: With `lk_valid` low, `lk_hit` is 0 and `lk_fault` is 0. No flag changes and the bad-address register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request present |
| lk_store | input | 1 | Lookup is a store (1) or load (0) |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 30 | Translated address, 0 when not hit |
| lk_fault | output | 2 | 0 none, 1 miss, 2 write protection |
| reg_we | input | 1 | Register write / command strobe |
| reg_sel | input | 3 | Register or command select |
| reg_wdata | input | 22 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (0 for command selects) |

## Verification
The assertions check, on every cycle, the properties that hold alone. They cover the random register's range and step, the capture and hold of the bad address, the quiet outputs of an idle cycle, the pass-through of the page offset, and the miss after a flush. The bench scenarios are what show the state-dependent behaviour. That includes which slot a command writes, the lowest-slot priority among duplicates, the reference and dirty bits read back through the read command, and the protection fault leaving the dirty bit clear.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 30;
  localparam int PG_W  = 12;
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int LO_W  = PPN_W + 4;

  typedef struct packed {
    logic             valid;
    logic             wr_ok;
    logic             refd;
    logic             dirty;
    logic [PPN_W-1:0] ppn;
    logic [VPN_W-1:0] vpn;
  } ent_t;

  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_MISS = 2'd1, FLT_PROT = 2'd2} flt_e;

  typedef enum logic [2:0] {
    SEL_INDEX = 3'd0, SEL_RAND = 3'd1, SEL_LO = 3'd2, SEL_HI = 3'd3,
    SEL_BADVA = 3'd4, SEL_WIDX = 3'd5, SEL_WRND = 3'd6, SEL_RIDX = 3'd7
  } sel_e;

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [VA_W-1:0] va);
    return {ppn, va[PG_W-1:0]};
  endfunction

  function automatic logic [LO_W-1:0] ent_lo(input ent_t e);
    return {e.valid, e.wr_ok, e.refd, e.dirty, e.ppn};
  endfunction

  function automatic ent_t ent_make(input logic [LO_W-1:0] lo,
                                    input logic [VPN_W-1:0] vpn);
    ent_t e;
    e.valid = lo[PPN_W+3];
    e.wr_ok = lo[PPN_W+2];
    e.refd  = lo[PPN_W+1];
    e.dirty = lo[PPN_W];
    e.ppn   = lo[PPN_W-1:0];
    e.vpn   = vpn;
    return e;
  endfunction
endpackage

// File: rtl/xlat_rand.sv
`timescale 1ns/1ps
module xlat_rand #(
  parameter int NUM_ENT = 16,
  parameter int WIRED   = 2,
  localparam int IW     = $clog2(NUM_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] rnd
);
  localparam logic [IW-1:0] TOP  = IW'(NUM_ENT - 1);
  localparam logic [IW-1:0] LOWR = IW'(WIRED);

  always_ff @(posedge clk) begin
    if (!rst_n)           rnd <= TOP;
    else if (rnd <= LOWR) rnd <= TOP;
    else                  rnd <= rnd - 1'b1;
  end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match import xlat_pkg::*; #(
  parameter int NUM_ENT = 16,
  localparam int IW     = $clog2(NUM_ENT)
) (
  input  logic [VPN_W-1:0]       vpn,
  input  ent_t [NUM_ENT-1:0]     ents,
  output logic                   found,
  output logic [IW-1:0]          sel
);
  logic [NUM_ENT-1:0] eq;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign eq[g] = ents[g].valid && (ents[g].vpn == vpn);
  end

  // scan downward so the lowest matching slot is the last one written
  always_comb begin
    found = |eq;
    sel   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (eq[i]) sel = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer import xlat_pkg::*; #(
  parameter int NUM_ENT = 16,
  parameter int WIRED   = 2,
  localparam int IW     = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic             lk_store,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [1:0]       lk_fault,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [LO_W-1:0]  reg_wdata,
  output logic [VA_W-1:0]  reg_rdata
);
  ent_t [NUM_ENT-1:0] ents;
  logic [IW-1:0]      idx_r;
  logic [LO_W-1:0]    lo_r;
  logic [VPN_W-1:0]   hi_r;
  logic [VA_W-1:0]    badva_r;
  logic [IW-1:0]      rnd;

  logic               found;
  logic [IW-1:0]      hsel;

  // named events
  logic ev_hit, ev_miss, ev_prot, ev_dirty;
  logic cmd_wr_idx, cmd_wr_rnd, cmd_rd, cmd_wr;
  logic [IW-1:0] wr_tgt;
  ent_t          wr_ent;

  xlat_rand #(.NUM_ENT(NUM_ENT), .WIRED(WIRED)) u_rand (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  xlat_match #(.NUM_ENT(NUM_ENT)) u_match (
    .vpn(lk_vaddr[VA_W-1:PG_W]), .ents(ents), .found(found), .sel(hsel)
  );

  assign ev_hit   = lk_valid && found;
  assign ev_miss  = lk_valid && !found;
  assign ev_prot  = ev_hit && lk_store && !ents[hsel].wr_ok;
  assign ev_dirty = ev_hit && lk_store && ents[hsel].wr_ok;

  assign cmd_wr_idx = reg_we && (reg_sel == SEL_WIDX);
  assign cmd_wr_rnd = reg_we && (reg_sel == SEL_WRND);
  assign cmd_rd     = reg_we && (reg_sel == SEL_RIDX);
  assign cmd_wr     = cmd_wr_idx || cmd_wr_rnd;
  assign wr_tgt     = cmd_wr_rnd ? rnd : idx_r;
  assign wr_ent     = ent_make(lo_r, hi_r);

  assign lk_hit   = ev_hit;
  assign lk_paddr = ev_hit ? join_pa(ents[hsel].ppn, lk_vaddr) : '0;
  assign lk_fault = ev_miss ? FLT_MISS : (ev_prot ? FLT_PROT : FLT_NONE);

  always_comb begin
    unique case (reg_sel)
      SEL_INDEX: reg_rdata = VA_W'(idx_r);
      SEL_RAND:  reg_rdata = VA_W'(rnd);
      SEL_LO:    reg_rdata = VA_W'(lo_r);
      SEL_HI:    reg_rdata = VA_W'(hi_r);
      SEL_BADVA: reg_rdata = badva_r;
      default:   reg_rdata = '0;
    endcase
  end

  // slot array: lookup flags, then command write, then flush
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (ev_hit && hsel == IW'(i)) begin
          ents[i].refd <= 1'b1;
          if (ev_dirty) ents[i].dirty <= 1'b1;
        end
        if (cmd_wr && wr_tgt == IW'(i)) ents[i] <= wr_ent;
        if (flush) ents[i].valid <= 1'b0;
      end
    end
  end

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_r   <= '0;
      lo_r    <= '0;
      hi_r    <= '0;
      badva_r <= '0;
    end else begin
      if (ev_miss || ev_prot) badva_r <= lk_vaddr;
      if (reg_we) begin
        case (reg_sel)
          SEL_INDEX: idx_r <= reg_wdata[IW-1:0];
          SEL_LO:    lo_r  <= reg_wdata;
          SEL_HI:    hi_r  <= reg_wdata[VPN_W-1:0];
          default: ;
        endcase
      end
      if (cmd_rd) begin
        lo_r <= ent_lo(ents[idx_r]);
        hi_r <= ents[idx_r].vpn;
      end
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk import xlat_pkg::*; #(
  parameter int NUM_ENT = 16,
  parameter int WIRED   = 2,
  localparam int IW     = $clog2(NUM_ENT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_paddr,
  input logic [1:0]      lk_fault,
  input logic            ev_miss,
  input logic            ev_prot,
  input logic [IW-1:0]   rnd,
  input logic [VA_W-1:0] badva_r
);
  a_r4_rand_range: assert property (@(posedge clk) disable iff (!rst_n)
    rnd >= IW'(WIRED));

  a_r4_rand_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rnd == (($past(rnd) == IW'(WIRED)) ? IW'(NUM_ENT - 1) : $past(rnd) - 1'b1));

  a_r3_bad_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss || ev_prot) |=> badva_r == $past(lk_vaddr));

  a_r3_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_miss || ev_prot) |=> $stable(badva_r));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_fault == 2'd0));

  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[PG_W-1:0] == lk_vaddr[PG_W-1:0]);

  a_r2_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault == 2'd1) |-> (!lk_hit && lk_paddr == '0));

  a_r10_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
endmodule

bind xlat_buffer xlat_buffer_chk #(.NUM_ENT(NUM_ENT), .WIRED(WIRED)) u_chk (.*);

// File: tb/xlat_buffer_test.sv
`timescale 1ns/1ps
module xlat_buffer_test;
  import xlat_pkg::*;
  localparam int N = 16;
  localparam int WIRED = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_valid = 1'b0, lk_store = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic lk_hit;
  logic [29:0] lk_paddr;
  logic [1:0] lk_fault;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [21:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  xlat_buffer uut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit [19:0] m_vpn[N];
  bit [17:0] m_ppn[N];
  bit m_v[N], m_d[N], m_r[N], m_w[N];
  int m_idx, m_rnd;
  bit [21:0] m_lo;
  bit [19:0] m_hi;
  bit [31:0] m_bad;
  int n_chk = 0, n_fail = 0;

  function automatic bit [21:0] mk_lo(bit v, bit w, bit [17:0] ppn);
    return {v, w, 2'b00, ppn};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit st, bit [31:0] va, bit fl,
                      bit we, bit [2:0] sel, bit [21:0] wd);
    int h;
    bit e_hit, e_miss, e_prot;
    bit [31:0] e_rd, e_pa;
    lk_valid = v; lk_store = st; lk_vaddr = va; flush = fl;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    #1;
    h = -1;
    for (int i = 0; i < N; i++) if (h < 0 && m_v[i] && m_vpn[i] == va[31:12]) h = i;
    e_hit  = v && (h >= 0);
    e_miss = v && (h < 0);
    e_prot = e_hit && st && !m_w[h];
    e_pa   = e_hit ? {2'b00, m_ppn[h], va[11:0]} : 32'd0;
    case (sel)
      3'd0: e_rd = m_idx;
      3'd1: e_rd = m_rnd;
      3'd2: e_rd = {10'd0, m_lo};
      3'd3: e_rd = {12'd0, m_hi};
      3'd4: e_rd = m_bad;
      default: e_rd = 0;
    endcase
    chk(tag, "hit", {31'd0, lk_hit}, {31'd0, e_hit});
    chk(tag, "fault", {30'd0, lk_fault}, e_miss ? 32'd1 : (e_prot ? 32'd2 : 32'd0));
    chk(tag, "paddr", {2'b00, lk_paddr}, e_pa);
    chk(tag, "rdata", reg_rdata, e_rd);
    @(posedge clk);
    if (we && sel == 3'd7) begin
      m_lo = {m_v[m_idx], m_w[m_idx], m_r[m_idx], m_d[m_idx], m_ppn[m_idx]};
      m_hi = m_vpn[m_idx];
    end
    if (e_hit) begin
      m_r[h] = 1;
      if (st && m_w[h]) m_d[h] = 1;
    end
    if (e_miss || e_prot) m_bad = va;
    if (we && (sel == 3'd5 || sel == 3'd6)) begin
      int t;
      t = (sel == 3'd6) ? m_rnd : m_idx;
      {m_v[t], m_w[t], m_r[t], m_d[t], m_ppn[t]} = m_lo;
      m_vpn[t] = m_hi;
    end
    if (we && sel == 3'd0) m_idx = wd[3:0];
    if (we && sel == 3'd2) m_lo = wd;
    if (we && sel == 3'd3) m_hi = wd[19:0];
    if (fl) for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rnd = (m_rnd <= WIRED) ? N - 1 : m_rnd - 1;
    @(negedge clk);
  endtask

  task automatic idle(string tag, bit [2:0] sel);
    step(tag, 0, 0, 32'h0, 0, 0, sel, 0);
  endtask

  task automatic reg_wr(string tag, bit [2:0] sel, bit [21:0] wd);
    step(tag, 0, 0, 32'h0, 0, 1, sel, wd);
  endtask

  task automatic load_slot(string tag, int slot, bit [19:0] vpn, bit [21:0] lo);
    reg_wr(tag, 3'd0, slot[21:0]);
    reg_wr(tag, 3'd2, lo);
    reg_wr(tag, 3'd3, {2'b00, vpn});
    reg_wr(tag, 3'd5, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_rnd = N - 1; m_idx = 0; m_lo = 0; m_hi = 0; m_bad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state: R4 random at 15, R3 bad address 0, R6 index 0, R2 empty buffer misses
    idle("R4", 3'd1);
    idle("R3", 3'd4);
    idle("R6", 3'd0);
    step("R2", 1, 0, 32'h0000_0ABC, 0, 0, 3'd4, 0);

    // R6 indexed write, R1 translation of loads
    load_slot("R6", 3, 20'hABCDE, mk_lo(1, 1, 18'h12345));
    step("R1", 1, 0, 32'hABCD_E123, 0, 0, 3'd2, 0);
    step("R1", 1, 0, 32'hABCD_EFFF, 0, 0, 3'd3, 0);

    // R2 miss and R3 capture
    step("R2", 1, 0, 32'h1111_1FFF, 0, 0, 3'd4, 0);
    idle("R3", 3'd4);
    step("R11", 0, 1, 32'hDEAD_BEEF, 0, 0, 3'd4, 0);

    // R5 random write
    reg_wr("R5", 3'd2, mk_lo(1, 1, 18'h0_0777));
    reg_wr("R5", 3'd3, 22'h0_5555);
    reg_wr("R5", 3'd6, 0);
    step("R5", 1, 0, 32'h0555_5010, 0, 0, 3'd1, 0);

    // R8 store hit sets dirty + reference; read back through select 7
    step("R8", 1, 1, 32'hABCD_E004, 0, 0, 3'd0, 0);
    reg_wr("R8", 3'd0, 22'd3);
    reg_wr("R8", 3'd7, 0);
    idle("R8", 3'd2);
    idle("R8", 3'd3);

    // R7 protection fault on a read-only slot
    load_slot("R7", 4, 20'h0BEEF, mk_lo(1, 0, 18'h2_0001));
    step("R7", 1, 1, 32'h0BEE_F800, 0, 0, 3'd4, 0);
    idle("R7", 3'd4);
    reg_wr("R7", 3'd7, 0);
    idle("R7", 3'd2);
    step("R8", 1, 0, 32'h0BEE_F000, 0, 0, 3'd0, 0);

    // R9 duplicate tags: slot 5 beats slot 9
    load_slot("R9", 9, 20'h7777A, mk_lo(1, 1, 18'h3_0009));
    load_slot("R9", 5, 20'h7777A, mk_lo(1, 1, 18'h0_0005));
    step("R9", 1, 0, 32'h7777_A321, 0, 0, 3'd0, 0);
    load_slot("R9", 5, 20'h7777A, mk_lo(0, 1, 18'h0_0005));
    step("R9", 1, 0, 32'h7777_A321, 0, 0, 3'd0, 0);

    // R4 random register walks through several wraps
    for (int k = 0; k < 40; k++) idle("R4", 3'd1);
    reg_wr("R5", 3'd6, 0);
    step("R5", 1, 0, 32'h0555_5ABC, 0, 0, 3'd1, 0);

    // R11 idle cycles leave everything untouched
    step("R11", 0, 1, 32'hABCD_E000, 0, 0, 3'd4, 0);
    reg_wr("R11", 3'd0, 22'd3);
    reg_wr("R11", 3'd7, 0);
    idle("R11", 3'd2);

    // R10 flush, also against a same-cycle write command
    step("R10", 1, 0, 32'hABCD_E000, 1, 1, 3'd5, 0);
    step("R10", 1, 0, 32'hABCD_E000, 0, 0, 3'd4, 0);
    step("R10", 1, 0, 32'h7777_A000, 0, 0, 3'd0, 0);
    step("R10", 1, 0, 32'h0BEE_F000, 0, 0, 3'd0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule